// File: doc/BRIEF.md
# Store-Conditional Instruction Decoder

This block takes one 32-bit store-conditional instruction word together with the base, data and second-data register values, and turns it into either a store request or an exception report. It handles four variants: a single word and a word pair, each in a plain form and in a form whose address is translated with user-mode rights while running privileged (the EVA form below). For the word forms, it rebuilds a 9-bit signed displacement from two fields that are not adjacent, sign-extends it and adds it to the base. The pair forms use the base alone. It then runs four configuration and alignment checks in a fixed priority order. Last, it packs the store data into a 64-bit field and sets the byte count.

The result is held in one output register with a valid/ready handshake. A word that does not decode as store-conditional is taken in and then dropped. Address translation, the memory write and the success writeback are handled outside this block.

Top module: `sc_decode_unit`

## Requirements
- R1: A word is recognised only when bits [31:26] = 101001, bits [14:11] = 1011, bit [10] = 0, bits [9:8] are 01 or 10, and bits [1:0] are 00 (word form) or 01 (pair form). An accepted unrecognised word produces no output (out_valid stays 0).
- R2: In the word form the displacement is {bit15, bits[7:2], 00}, sign-extended from 9 bits. out_addr = base + displacement and out_nbytes = 4.
- R3: In the pair form the displacement is zero, out_addr = base and out_nbytes = 8.
- R4: out_eva is 1 when bits [9:8] = 10 and 0 when they are 01.
- R5: A pair form with cfg_pair_absent = 1 reports out_exc_code = 1 (reserved instruction). This check has priority over every other check.
- R6: Otherwise, an EVA form with cfg_eva_present = 0 reports out_exc_code = 1.
- R7: Otherwise, an EVA form with cfg_kernel = 0 reports out_exc_code = 2 (coprocessor unusable).
- R8: Otherwise, an address that is not a multiple of out_nbytes reports out_exc_code = 3 (address error on store), and out_addr carries the offending address. With no check failing, out_exc_code = 0.
- R9: The word form's out_data is {32'h0, rt}.
- R10: The pair form's out_data is {rt, ru} when cfg_big_endian = 1 and {ru, rt} when it is 0.
- R11: An input is accepted on a clock edge where in_valid and in_ready are both 1, and its result appears on the next cycle. in_ready = !out_valid || out_ready. While out_valid = 1 and out_ready = 0, the outputs hold steady.
- R12: Synchronous reset clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Block can accept this cycle |
| in_instr | input | 32 | Instruction word |
| in_base | input | 32 | Base register value |
| in_rt | input | 32 | First data register value |
| in_ru | input | 32 | Second data register value (pair forms) |
| cfg_eva_present | input | 1 | EVA forms implemented |
| cfg_pair_absent | input | 1 | Paired-word support missing |
| cfg_big_endian | input | 1 | Big-endian word ordering |
| cfg_kernel | input | 1 | Privileged access granted |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_exc_code | output | 2 | 0 store request, 1 reserved instr, 2 coprocessor unusable, 3 address error |
| out_addr | output | 32 | Effective (or faulting) address |
| out_data | output | 64 | Packed store data |
| out_nbytes | output | 4 | Byte count, 4 or 8 |
| out_eva | output | 1 | EVA form flag |

## Verification
The bench sets several checks to fail at once and expects only the highest-priority one to be reported. A design with the wrong check order would report the address error or the privilege fault in place of the reserved-instruction code. Displacements at both ends of the 9-bit range, including the most negative one, catch a design that drops the sign bit at bit 15 or extends it from the wrong position. Pairs are checked in both byte orders, and a base that is aligned to 4 but not to 8 is sent with a pair. A design that swaps the halves, or checks alignment with the word mask, fails these cases. Words that break a single field of the pattern must produce no output. A back-pressure case checks that the held result does not change.

// File: rtl/sc_dec_pkg.sv
package sc_dec_pkg;
    localparam int INSTR_W  = 32;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int DATA_W   = 2 * WORD_W;
    localparam int DISP_W   = 9;
    localparam int NB_W     = 4;
    localparam int WORD_NB  = WORD_W / 8;
    localparam int PAIR_NB  = DATA_W / 8;

    localparam logic [5:0] MAJOR_OP = 6'b101001;
    localparam logic [3:0] MINOR_OP = 4'b1011;
    localparam logic [1:0] SEL_PLAIN = 2'b01;
    localparam logic [1:0] SEL_EVA   = 2'b10;
    localparam logic [1:0] TAIL_WORD = 2'b00;
    localparam logic [1:0] TAIL_PAIR = 2'b01;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_RSVD = 2'd1,
        EXC_COPU = 2'd2,
        EXC_ADST = 2'd3
    } exc_code_e;

    typedef struct packed {
        logic              hit;
        logic              is_pair;
        logic              is_eva;
        logic [ADDR_W-1:0] disp;
        logic [NB_W-1:0]   nbytes;
    } dec_info_t;

    typedef struct packed {
        exc_code_e         code;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [NB_W-1:0]   nbytes;
        logic              eva;
    } sc_result_t;

    function automatic logic [ADDR_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic misaligned(input logic [ADDR_W-1:0] a,
                                        input logic [NB_W-1:0] nb);
        logic [ADDR_W-1:0] mask;
        mask = {{(ADDR_W-NB_W){1'b0}}, nb} - 1'b1;
        return (a & mask) != '0;
    endfunction
endpackage

// File: rtl/sc_field_decoder.sv
module sc_field_decoder
    import sc_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_info_t          info
);
    logic       major_ok;
    logic       minor_ok;
    logic       sel_ok;
    logic       tail_word;
    logic       tail_pair;
    logic [DISP_W-1:0] disp_raw;

    always_comb begin
        major_ok  = instr[31:26] == MAJOR_OP;
        minor_ok  = (instr[14:11] == MINOR_OP) && !instr[10];
        sel_ok    = (instr[9:8] == SEL_PLAIN) || (instr[9:8] == SEL_EVA);
        tail_word = instr[1:0] == TAIL_WORD;
        tail_pair = instr[1:0] == TAIL_PAIR;
        disp_raw  = {instr[15], instr[7:2], 2'b00};

        info.hit     = major_ok && minor_ok && sel_ok && (tail_word || tail_pair);
        info.is_pair = tail_pair;
        info.is_eva  = instr[9:8] == SEL_EVA;
        info.disp    = tail_pair ? '0 : sext_disp(disp_raw);
        info.nbytes  = tail_pair ? NB_W'(PAIR_NB) : NB_W'(WORD_NB);
    end
endmodule

// File: rtl/sc_check_chain.sv
module sc_check_chain
    import sc_dec_pkg::*;
(
    input  dec_info_t          info,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               eva_present,
    input  logic               pair_absent,
    input  logic               kernel,
    output exc_code_e          code
);
    localparam int N_CHK = 4;
    logic      [N_CHK-1:0] fail;
    exc_code_e             code_of [N_CHK];

    always_comb begin
        fail[0] = info.is_pair && pair_absent;
        fail[1] = info.is_eva && !eva_present;
        fail[2] = info.is_eva && !kernel;
        fail[3] = misaligned(addr, info.nbytes);
        code_of[0] = EXC_RSVD;
        code_of[1] = EXC_RSVD;
        code_of[2] = EXC_COPU;
        code_of[3] = EXC_ADST;
        code = EXC_NONE;
        for (int i = N_CHK - 1; i >= 0; i--) begin
            if (fail[i]) code = code_of[i];
        end
    end
endmodule

// File: rtl/sc_data_packer.sv
module sc_data_packer
    import sc_dec_pkg::*;
(
    input  logic [WORD_W-1:0] rt_val,
    input  logic [WORD_W-1:0] ru_val,
    input  logic              is_pair,
    input  logic              big_endian,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        if (!is_pair)
            data = {{WORD_W{1'b0}}, rt_val};
        else if (big_endian)
            data = {rt_val, ru_val};
        else
            data = {ru_val, rt_val};
    end
endmodule

// File: rtl/sc_decode_unit.sv
module sc_decode_unit
    import sc_dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [31:0]         in_instr,
    input  logic [31:0]         in_base,
    input  logic [31:0]         in_rt,
    input  logic [31:0]         in_ru,
    input  logic                cfg_eva_present,
    input  logic                cfg_pair_absent,
    input  logic                cfg_big_endian,
    input  logic                cfg_kernel,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [1:0]          out_exc_code,
    output logic [31:0]         out_addr,
    output logic [63:0]         out_data,
    output logic [3:0]          out_nbytes,
    output logic                out_eva
);
    dec_info_t         info;
    logic [ADDR_W-1:0] eff_addr;
    exc_code_e         code;
    logic [DATA_W-1:0] packed_data;
    sc_result_t        nxt_q;
    sc_result_t        res_q;
    logic              vld_q;

    sc_field_decoder u_dec (
        .instr (in_instr),
        .info  (info)
    );

    assign eff_addr = in_base + info.disp;

    sc_check_chain u_chk (
        .info        (info),
        .addr        (eff_addr),
        .eva_present (cfg_eva_present),
        .pair_absent (cfg_pair_absent),
        .kernel      (cfg_kernel),
        .code        (code)
    );

    sc_data_packer u_pack (
        .rt_val     (in_rt),
        .ru_val     (in_ru),
        .is_pair    (info.is_pair),
        .big_endian (cfg_big_endian),
        .data       (packed_data)
    );

    always_comb begin
        nxt_q.code   = code;
        nxt_q.addr   = eff_addr;
        nxt_q.data   = (code == EXC_NONE) ? packed_data : '0;
        nxt_q.nbytes = info.nbytes;
        nxt_q.eva    = info.is_eva;
    end

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else if (in_ready) begin
            vld_q <= in_valid && info.hit;
            if (in_valid && info.hit) res_q <= nxt_q;
        end
    end

    assign out_valid    = vld_q;
    assign out_exc_code = res_q.code;
    assign out_addr     = res_q.addr;
    assign out_data     = res_q.data;
    assign out_nbytes   = res_q.nbytes;
    assign out_eva      = res_q.eva;
endmodule

// File: rtl/sc_decode_unit_chk.sv
module sc_decode_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic        in_ready,
    input logic [31:0] in_instr,
    input logic        out_valid,
    input logic        out_ready,
    input logic [1:0]  out_exc_code,
    input logic [31:0] out_addr,
    input logic [63:0] out_data,
    input logic [3:0]  out_nbytes
);
    logic major_bad;
    assign major_bad = in_instr[31:26] != 6'b101001;

    assert_reset_idle_R12: assert property (@(posedge clk) rst |=> !out_valid);

    assert_drop_unknown_R1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && major_bad) |=> !out_valid);

    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
            && $stable(out_data) && $stable(out_exc_code)));

    assert_bad_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exc_code == 2'd3) |->
            ((out_addr & ({28'h0, out_nbytes} - 32'd1)) != 32'd0));

    assert_aligned_req_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exc_code == 2'd0) |->
            ((out_addr & ({28'h0, out_nbytes} - 32'd1)) == 32'd0));

    assert_word_zext_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_exc_code == 2'd0 && out_nbytes == 4'd4) |->
            (out_data[63:32] == 32'h0));

    assert_size_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_nbytes == 4'd4 || out_nbytes == 4'd8));
endmodule

bind sc_decode_unit sc_decode_unit_chk u_sc_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_instr     (in_instr),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_exc_code (out_exc_code),
    .out_addr     (out_addr),
    .out_data     (out_data),
    .out_nbytes   (out_nbytes)
);

// File: tb/sc_decode_unit_tb.sv
module sc_decode_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0, in_base = '0, in_rt = '0, in_ru = '0;
    logic        cfg_eva_present = 1'b1, cfg_pair_absent = 1'b0;
    logic        cfg_big_endian = 1'b0, cfg_kernel = 1'b1;
    logic        out_valid, out_ready = 1'b1, out_eva;
    logic [1:0]  out_exc_code;
    logic [31:0] out_addr;
    logic [63:0] out_data;
    logic [3:0]  out_nbytes;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sc_decode_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .in_base(in_base), .in_rt(in_rt), .in_ru(in_ru),
        .cfg_eva_present(cfg_eva_present), .cfg_pair_absent(cfg_pair_absent),
        .cfg_big_endian(cfg_big_endian), .cfg_kernel(cfg_kernel),
        .out_valid(out_valid), .out_ready(out_ready), .out_exc_code(out_exc_code),
        .out_addr(out_addr), .out_data(out_data), .out_nbytes(out_nbytes),
        .out_eva(out_eva)
    );

    function automatic logic [31:0] mk_word(input logic eva, input logic [8:0] d);
        return {6'b101001, 5'd3, 5'd4, d[8], 4'b1011, 1'b0,
                eva ? 2'b10 : 2'b01, d[7:2], 2'b00};
    endfunction

    function automatic logic [31:0] mk_pair(input logic eva);
        return {6'b101001, 5'd3, 5'd4, 1'b0, 4'b1011, 1'b0,
                eva ? 2'b10 : 2'b01, 5'd7, 1'b0, 2'b01};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] ins, input logic [31:0] base,
                        input logic [31:0] rt, input logic [31:0] ru);
        @(negedge clk);
        in_instr = ins; in_base = base; in_rt = rt; in_ru = ru; in_valid = 1'b1;
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic ep, input logic pa, input logic be, input logic kr);
        cfg_eva_present = ep; cfg_pair_absent = pa; cfg_big_endian = be; cfg_kernel = kr;
    endtask

    task automatic t_reset;
        chk("R12 out_valid in reset", {63'h0, out_valid}, 64'h0);
        chk("R11 in_ready idle", {63'h0, in_ready}, 64'h1);
    endtask

    task automatic t_word_disp;
        set_cfg(1, 0, 0, 1);
        send(mk_word(0, 9'h1FC), 32'h0000_1000, 32'hDEAD_BEEF, 32'h0);
        chk("R1 word recognised", {63'h0, out_valid}, 64'h1);
        chk("R2 addr -4", {32'h0, out_addr}, 64'h0000_0FFC);
        chk("R2 nbytes", {60'h0, out_nbytes}, 64'h4);
        chk("R8 no exc", {62'h0, out_exc_code}, 64'h0);
        chk("R9 word data", out_data, 64'h0000_0000_DEAD_BEEF);
        chk("R4 plain flag", {63'h0, out_eva}, 64'h0);
        send(mk_word(0, 9'h0FC), 32'h0000_1000, 32'h1, 32'h0);
        chk("R2 addr +252", {32'h0, out_addr}, 64'h0000_10FC);
        send(mk_word(0, 9'h100), 32'h0000_1000, 32'h1, 32'h0);
        chk("R2 addr -256", {32'h0, out_addr}, 64'h0000_0F00);
    endtask

    task automatic t_pair_data;
        set_cfg(1, 0, 0, 1);
        send(mk_pair(0), 32'h0000_2008, 32'h1111_1111, 32'h2222_2222);
        chk("R3 pair addr", {32'h0, out_addr}, 64'h0000_2008);
        chk("R3 pair nbytes", {60'h0, out_nbytes}, 64'h8);
        chk("R10 little endian", out_data, 64'h2222_2222_1111_1111);
        set_cfg(1, 0, 1, 1);
        send(mk_pair(0), 32'h0000_2008, 32'h1111_1111, 32'h2222_2222);
        chk("R10 big endian", out_data, 64'h1111_1111_2222_2222);
        chk("R8 pair aligned", {62'h0, out_exc_code}, 64'h0);
    endtask

    task automatic t_eva;
        set_cfg(1, 0, 0, 1);
        send(mk_word(1, 9'h004), 32'h0000_0100, 32'h5, 32'h0);
        chk("R4 eva flag", {63'h0, out_eva}, 64'h1);
        chk("R7 kernel ok", {62'h0, out_exc_code}, 64'h0);
        chk("R2 eva addr", {32'h0, out_addr}, 64'h0000_0104);
    endtask

    task automatic t_priority;
        set_cfg(0, 1, 0, 0);
        send(mk_pair(1), 32'h0000_0004, 32'h0, 32'h0);
        chk("R5 pair-absent first", {62'h0, out_exc_code}, 64'h1);
        set_cfg(0, 0, 0, 0);
        send(mk_pair(1), 32'h0000_0004, 32'h0, 32'h0);
        chk("R6 eva-absent next", {62'h0, out_exc_code}, 64'h1);
        set_cfg(1, 0, 0, 0);
        send(mk_pair(1), 32'h0000_0004, 32'h0, 32'h0);
        chk("R7 privilege next", {62'h0, out_exc_code}, 64'h2);
        set_cfg(1, 0, 0, 1);
        send(mk_pair(1), 32'h0000_0004, 32'h0, 32'h0);
        chk("R8 pair misaligned", {62'h0, out_exc_code}, 64'h3);
        chk("R8 bad addr", {32'h0, out_addr}, 64'h0000_0004);
        send(mk_word(0, 9'h000), 32'h0000_0102, 32'h0, 32'h0);
        chk("R8 word misaligned", {62'h0, out_exc_code}, 64'h3);
        chk("R8 word bad addr", {32'h0, out_addr}, 64'h0000_0102);
        set_cfg(1, 1, 0, 1);
        send(mk_word(0, 9'h000), 32'h0000_0100, 32'h0, 32'h0);
        chk("R5 word ignores pair-absent", {62'h0, out_exc_code}, 64'h0);
    endtask

    task automatic t_unknown;
        logic [31:0] good;
        set_cfg(1, 0, 0, 1);
        good = mk_word(0, 9'h0);
        send(good ^ 32'h8000_0000, 32'h0, 32'h0, 32'h0);
        chk("R1 bad major", {63'h0, out_valid}, 64'h0);
        send(good ^ 32'h0000_0400, 32'h0, 32'h0, 32'h0);
        chk("R1 bit10 set", {63'h0, out_valid}, 64'h0);
        send(good | 32'h0000_0300, 32'h0, 32'h0, 32'h0);
        chk("R1 select 11", {63'h0, out_valid}, 64'h0);
        send(good | 32'h0000_0002, 32'h0, 32'h0, 32'h0);
        chk("R1 tail 10", {63'h0, out_valid}, 64'h0);
    endtask

    task automatic t_backpressure;
        set_cfg(1, 0, 0, 1);
        out_ready = 1'b0;
        send(mk_word(0, 9'h008), 32'h0000_0300, 32'hCAFE_0001, 32'h0);
        chk("R11 result after one cycle", {63'h0, out_valid}, 64'h1);
        chk("R11 in_ready low when stalled", {63'h0, in_ready}, 64'h0);
        send(mk_word(0, 9'h010), 32'h0000_0900, 32'h7, 32'h0);
        chk("R11 held valid", {63'h0, out_valid}, 64'h1);
        chk("R11 held addr", {32'h0, out_addr}, 64'h0000_0308);
        chk("R11 held data", out_data, 64'h0000_0000_CAFE_0001);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R11 drained", {63'h0, out_valid}, 64'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_word_disp();
        t_pair_data();
        t_eva();
        t_priority();
        t_unknown();
        t_backpressure();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R12 reset clears", {63'h0, out_valid}, 64'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule